// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block is the combinational hazard controller for a five-stage in-order pipeline (fetch, decode with register read, execute, memory, writeback) in which one memory port serves both instruction fetch and data access. It looks at the register names and control bits held in the pipeline registers. From them it produces the operand bypass selects for the execute stage, the enables for the program counter and the fetch/decode register, a bubble into execute, a flush of the fetch/decode register, a redirect strobe for a taken branch, and the grant of the shared memory port to fetch.

Registers are read in decode and written in writeback, so only read-after-write conflicts exist. Most of these are resolved by bypassing from the memory or writeback stage. A load whose result is needed by the very next instruction costs one interlock cycle. Branches resolve in decode under a predict-not-taken policy: a taken branch squashes the single instruction fetched behind it. A load or store in the memory stage takes the memory port, so fetch skips that cycle and a bubble enters decode. When this coincides with a load-use interlock, the two stalls merge so that no instruction is lost or duplicated.

All pins are plain control levels with no handshake. The datapath applies them in the same cycle. A cleared pipeline register has priority over its enable.

Top module: `hzd_ctrl`

## Requirements
- R1: Each execute operand select is encoded 0 = register file, 1 = memory-stage result, 2 = writeback-stage result, and never 3. It is 1 when the memory stage writes a nonzero register equal to that operand's source.
- R2: When the memory stage does not match, a select is 2 if the writeback stage writes a nonzero register equal to that source. Otherwise it is 0.
- R3: When both the memory and writeback stages write the operand's source register, the memory-stage result (select 1) wins.
- R4: Register 0 is never bypassed (select 0) and never causes a load-use interlock.
- R5: If execute holds a load whose nonzero destination equals a decode source flagged as used, then pc_en_o=0, ifid_en_o=0 and idex_bubble_o=1, and ifid_flush_o=0.
- R6: A decode source whose used flag is low, or a non-load instruction in execute, never causes an interlock.
- R7: A data access in the memory stage (without load-use) gives fetch_en_o=0, pc_en_o=0 unless a branch redirects, ifid_flush_o=1, ifid_en_o=1 and idex_bubble_o=0.
- R8: When a data access and a load-use interlock occur together, the outputs are pc_en_o=0, ifid_en_o=0, ifid_flush_o=0, idex_bubble_o=1 and fetch_en_o=0. The decode instruction is held, not cleared.
- R9: A taken branch in decode with no load-use interlock gives pc_redirect_o=1, pc_en_o=1 and ifid_flush_o=1, also during a memory-port stall.
- R10: A taken branch during a load-use interlock is not acted on (pc_redirect_o=0). A not-taken branch flushes nothing.
- R11: With no hazard, the outputs are pc_en_o=1, ifid_en_o=1, fetch_en_o=1, both selects 0, and all flush, bubble and redirect outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1_i | input | REG_ADDR_W | First source register of the decode instruction |
| id_rs2_i | input | REG_ADDR_W | Second source register of the decode instruction |
| id_rs1_used_i | input | 1 | Decode instruction reads its first source |
| id_rs2_used_i | input | 1 | Decode instruction reads its second source |
| id_branch_taken_i | input | 1 | Branch in decode resolved taken |
| ex_rd_i | input | REG_ADDR_W | Destination register of the execute instruction |
| ex_is_load_i | input | 1 | Execute instruction is a load |
| ex_rs1_i | input | REG_ADDR_W | First source of the execute instruction |
| ex_rs2_i | input | REG_ADDR_W | Second source of the execute instruction |
| mem_rd_i | input | REG_ADDR_W | Destination register of the memory-stage instruction |
| mem_reg_wr_i | input | 1 | Memory-stage instruction writes a register |
| mem_data_access_i | input | 1 | Memory-stage instruction is a load or store |
| wb_rd_i | input | REG_ADDR_W | Destination register of the writeback instruction |
| wb_reg_wr_i | input | 1 | Writeback instruction writes a register |
| fwd_a_sel_o | output | 2 | Operand A bypass select |
| fwd_b_sel_o | output | 2 | Operand B bypass select |
| pc_en_o | output | 1 | Program counter update enable |
| pc_redirect_o | output | 1 | Program counter loads the branch target |
| ifid_en_o | output | 1 | Fetch/decode register load enable |
| ifid_flush_o | output | 1 | Fetch/decode register clears to a bubble |
| idex_bubble_o | output | 1 | Decode/execute register clears to a bubble |
| fetch_en_o | output | 1 | Memory port granted to instruction fetch |

## Verification
The bench builds the block with REG_ADDR_W=2, so only four registers exist. This makes it possible to enumerate every aliasing of the execute sources against the memory and writeback destinations (1024 cases). It also covers every pairing of decode sources, used flags, load destination, port conflict and branch outcome (2048 cases). Register 0, the double-match priority case and every combination of simultaneous stalls are therefore hit directly, not sampled.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int FWD_SEL_W = 2;
  localparam int NUM_SRC   = 2;

  typedef enum logic [FWD_SEL_W-1:0] {
    FWD_RF  = 2'd0,
    FWD_MEM = 2'd1,
    FWD_WB  = 2'd2
  } fwd_sel_e;
endpackage

// File: rtl/hzd_fwd_sel.sv
module hzd_fwd_sel #(
  parameter int REG_ADDR_W = 5
) (
  input  logic [REG_ADDR_W-1:0] src_i,
  input  logic [REG_ADDR_W-1:0] mem_rd_i,
  input  logic                  mem_wr_i,
  input  logic [REG_ADDR_W-1:0] wb_rd_i,
  input  logic                  wb_wr_i,
  output hzd_pkg::fwd_sel_e     sel_o
);
  logic mem_hit, wb_hit;

  assign mem_hit = mem_wr_i && (mem_rd_i != '0) && (mem_rd_i == src_i);
  assign wb_hit  = wb_wr_i  && (wb_rd_i  != '0) && (wb_rd_i  == src_i);

  // the younger result (memory stage) takes precedence
  always_comb begin
    sel_o = hzd_pkg::FWD_RF;
    if (wb_hit)  sel_o = hzd_pkg::FWD_WB;
    if (mem_hit) sel_o = hzd_pkg::FWD_MEM;
  end
endmodule

// File: rtl/hzd_load_use.sv
module hzd_load_use #(
  parameter int REG_ADDR_W = 5,
  parameter int NSRC       = 2
) (
  input  logic [REG_ADDR_W-1:0] src_i  [NSRC],
  input  logic [NSRC-1:0]       used_i,
  input  logic [REG_ADDR_W-1:0] ex_rd_i,
  input  logic                  ex_load_i,
  output logic                  stall_o
);
  logic [NSRC-1:0] hit;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign hit[s] = used_i[s] && (src_i[s] == ex_rd_i);
  end

  assign stall_o = ex_load_i && (ex_rd_i != '0) && (|hit);
endmodule

// File: rtl/hzd_flow_ctl.sv
module hzd_flow_ctl (
  input  logic load_use_i,
  input  logic data_access_i,
  input  logic branch_taken_i,
  output logic pc_en_o,
  output logic pc_redirect_o,
  output logic ifid_en_o,
  output logic ifid_flush_o,
  output logic idex_bubble_o,
  output logic fetch_en_o
);
  logic redirect;

  // a branch is only acted on once its decode slot is not interlocked
  assign redirect      = branch_taken_i & ~load_use_i;
  assign pc_redirect_o = redirect;
  // PC holds on any stall, but a redirect still loads the target
  assign pc_en_o       = ~load_use_i & (~data_access_i | redirect);
  // interlock holds decode; otherwise a missed fetch or wrong path clears it
  assign ifid_en_o     = ~load_use_i;
  assign ifid_flush_o  = ~load_use_i & (data_access_i | branch_taken_i);
  assign idex_bubble_o = load_use_i;
  assign fetch_en_o    = ~data_access_i;
endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl #(
  parameter int REG_ADDR_W = 5
) (
  input  logic [REG_ADDR_W-1:0] id_rs1_i,
  input  logic [REG_ADDR_W-1:0] id_rs2_i,
  input  logic                  id_rs1_used_i,
  input  logic                  id_rs2_used_i,
  input  logic                  id_branch_taken_i,
  input  logic [REG_ADDR_W-1:0] ex_rd_i,
  input  logic                  ex_is_load_i,
  input  logic [REG_ADDR_W-1:0] ex_rs1_i,
  input  logic [REG_ADDR_W-1:0] ex_rs2_i,
  input  logic [REG_ADDR_W-1:0] mem_rd_i,
  input  logic                  mem_reg_wr_i,
  input  logic                  mem_data_access_i,
  input  logic [REG_ADDR_W-1:0] wb_rd_i,
  input  logic                  wb_reg_wr_i,
  output logic [1:0]            fwd_a_sel_o,
  output logic [1:0]            fwd_b_sel_o,
  output logic                  pc_en_o,
  output logic                  pc_redirect_o,
  output logic                  ifid_en_o,
  output logic                  ifid_flush_o,
  output logic                  idex_bubble_o,
  output logic                  fetch_en_o
);
  localparam int NSRC = hzd_pkg::NUM_SRC;

  logic [REG_ADDR_W-1:0] ex_src [NSRC];
  logic [REG_ADDR_W-1:0] id_src [NSRC];
  logic [NSRC-1:0]       id_used;
  hzd_pkg::fwd_sel_e     fwd_sel [NSRC];
  logic                  load_use;

  assign ex_src[0] = ex_rs1_i;
  assign ex_src[1] = ex_rs2_i;
  assign id_src[0] = id_rs1_i;
  assign id_src[1] = id_rs2_i;
  assign id_used   = {id_rs2_used_i, id_rs1_used_i};

  for (genvar k = 0; k < NSRC; k++) begin : g_fwd
    hzd_fwd_sel #(.REG_ADDR_W(REG_ADDR_W)) u_sel (
      .src_i    (ex_src[k]),
      .mem_rd_i (mem_rd_i),
      .mem_wr_i (mem_reg_wr_i),
      .wb_rd_i  (wb_rd_i),
      .wb_wr_i  (wb_reg_wr_i),
      .sel_o    (fwd_sel[k])
    );
  end

  assign fwd_a_sel_o = fwd_sel[0];
  assign fwd_b_sel_o = fwd_sel[1];

  hzd_load_use #(.REG_ADDR_W(REG_ADDR_W), .NSRC(NSRC)) u_lu (
    .src_i     (id_src),
    .used_i    (id_used),
    .ex_rd_i   (ex_rd_i),
    .ex_load_i (ex_is_load_i),
    .stall_o   (load_use)
  );

  hzd_flow_ctl u_flow (
    .load_use_i     (load_use),
    .data_access_i  (mem_data_access_i),
    .branch_taken_i (id_branch_taken_i),
    .pc_en_o        (pc_en_o),
    .pc_redirect_o  (pc_redirect_o),
    .ifid_en_o      (ifid_en_o),
    .ifid_flush_o   (ifid_flush_o),
    .idex_bubble_o  (idex_bubble_o),
    .fetch_en_o     (fetch_en_o)
  );
endmodule

// File: rtl/hzd_ctrl_chk.sv
module hzd_ctrl_chk #(
  parameter int REG_ADDR_W = 5
) (
  input logic [REG_ADDR_W-1:0] id_rs1_i,
  input logic [REG_ADDR_W-1:0] id_rs2_i,
  input logic                  id_rs1_used_i,
  input logic                  id_rs2_used_i,
  input logic                  id_branch_taken_i,
  input logic [REG_ADDR_W-1:0] ex_rd_i,
  input logic                  ex_is_load_i,
  input logic [REG_ADDR_W-1:0] ex_rs1_i,
  input logic [REG_ADDR_W-1:0] ex_rs2_i,
  input logic [REG_ADDR_W-1:0] mem_rd_i,
  input logic                  mem_reg_wr_i,
  input logic                  mem_data_access_i,
  input logic [REG_ADDR_W-1:0] wb_rd_i,
  input logic                  wb_reg_wr_i,
  input logic [1:0]            fwd_a_sel_o,
  input logic [1:0]            fwd_b_sel_o,
  input logic                  pc_en_o,
  input logic                  pc_redirect_o,
  input logic                  ifid_en_o,
  input logic                  ifid_flush_o,
  input logic                  idex_bubble_o,
  input logic                  fetch_en_o
);
  logic known;
  assign known = !$isunknown({id_rs1_i, id_rs2_i, id_rs1_used_i, id_rs2_used_i,
                              id_branch_taken_i, ex_rd_i, ex_is_load_i, ex_rs1_i,
                              ex_rs2_i, mem_rd_i, mem_reg_wr_i, mem_data_access_i,
                              wb_rd_i, wb_reg_wr_i, fwd_a_sel_o, fwd_b_sel_o,
                              pc_en_o, pc_redirect_o, ifid_en_o, ifid_flush_o,
                              idex_bubble_o, fetch_en_o});

  always_comb begin
    if (known) begin
      AST_SEL_LEGAL: assert (fwd_a_sel_o != 2'd3 && fwd_b_sel_o != 2'd3) else $error("illegal select"); // R1
      AST_MEM_WINS_A: assert (!(mem_reg_wr_i && mem_rd_i != '0 && mem_rd_i == ex_rs1_i) || fwd_a_sel_o == 2'd1) else $error("A memory bypass"); // R3
      AST_MEM_WINS_B: assert (!(mem_reg_wr_i && mem_rd_i != '0 && mem_rd_i == ex_rs2_i) || fwd_b_sel_o == 2'd1) else $error("B memory bypass"); // R3
      AST_WB_ONLY_A: assert (!(fwd_a_sel_o == 2'd2) || (wb_reg_wr_i && wb_rd_i == ex_rs1_i)) else $error("A wb bypass"); // R2
      AST_ZERO_NOT_FWD_A: assert (ex_rs1_i != '0 || fwd_a_sel_o == 2'd0) else $error("r0 bypass A"); // R4
      AST_ZERO_NOT_FWD_B: assert (ex_rs2_i != '0 || fwd_b_sel_o == 2'd0) else $error("r0 bypass B"); // R4
      AST_LU_HOLDS: assert (!idex_bubble_o || (!pc_en_o && !ifid_en_o && !ifid_flush_o && !pc_redirect_o)) else $error("interlock shape"); // R5
      AST_NO_LU_WITHOUT_LOAD: assert (ex_is_load_i || !idex_bubble_o) else $error("bubble without load"); // R6
      AST_PORT_TO_DATA: assert (!mem_data_access_i || !fetch_en_o) else $error("fetch during data access"); // R7
      AST_MERGED_NO_LOSS: assert (!(ifid_flush_o && !ifid_en_o)) else $error("flush while held"); // R8
      AST_REDIRECT_FLUSH: assert (!pc_redirect_o || (pc_en_o && ifid_flush_o)) else $error("redirect shape"); // R9
      AST_NOT_TAKEN_KEEPS: assert (id_branch_taken_i || mem_data_access_i || !ifid_flush_o) else $error("spurious flush"); // R10
    end
  end
endmodule

bind hzd_ctrl hzd_ctrl_chk #(.REG_ADDR_W(REG_ADDR_W)) u_chk (
  .id_rs1_i(id_rs1_i), .id_rs2_i(id_rs2_i),
  .id_rs1_used_i(id_rs1_used_i), .id_rs2_used_i(id_rs2_used_i),
  .id_branch_taken_i(id_branch_taken_i),
  .ex_rd_i(ex_rd_i), .ex_is_load_i(ex_is_load_i),
  .ex_rs1_i(ex_rs1_i), .ex_rs2_i(ex_rs2_i),
  .mem_rd_i(mem_rd_i), .mem_reg_wr_i(mem_reg_wr_i),
  .mem_data_access_i(mem_data_access_i),
  .wb_rd_i(wb_rd_i), .wb_reg_wr_i(wb_reg_wr_i),
  .fwd_a_sel_o(fwd_a_sel_o), .fwd_b_sel_o(fwd_b_sel_o),
  .pc_en_o(pc_en_o), .pc_redirect_o(pc_redirect_o),
  .ifid_en_o(ifid_en_o), .ifid_flush_o(ifid_flush_o),
  .idex_bubble_o(idex_bubble_o), .fetch_en_o(fetch_en_o)
);

// File: tb/hzd_ctrl_tb.sv
module hzd_ctrl_tb;
  localparam int AW = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [AW-1:0] id_rs1, id_rs2, ex_rd, ex_rs1, ex_rs2, mem_rd, wb_rd;
  logic id_u1, id_u2, br, ex_load, mem_wr, mem_acc, wb_wr;
  logic [1:0] fwd_a, fwd_b;
  logic pc_en, pc_redir, ifid_en, ifid_flush, idex_bub, fetch_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  hzd_ctrl #(.REG_ADDR_W(AW)) u_dut (
    .id_rs1_i(id_rs1), .id_rs2_i(id_rs2),
    .id_rs1_used_i(id_u1), .id_rs2_used_i(id_u2),
    .id_branch_taken_i(br),
    .ex_rd_i(ex_rd), .ex_is_load_i(ex_load),
    .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2),
    .mem_rd_i(mem_rd), .mem_reg_wr_i(mem_wr),
    .mem_data_access_i(mem_acc),
    .wb_rd_i(wb_rd), .wb_reg_wr_i(wb_wr),
    .fwd_a_sel_o(fwd_a), .fwd_b_sel_o(fwd_b),
    .pc_en_o(pc_en), .pc_redirect_o(pc_redir),
    .ifid_en_o(ifid_en), .ifid_flush_o(ifid_flush),
    .idex_bubble_o(idex_bub), .fetch_en_o(fetch_en)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_inputs();
    {id_rs1, id_rs2, ex_rd, ex_rs1, ex_rs2, mem_rd, wb_rd} = '0;
    {id_u1, id_u2, br, ex_load, mem_wr, mem_acc, wb_wr} = '0;
  endtask

  // R1/R2/R3/R4 bypass model: 1 = memory stage, 2 = writeback, 0 = register file
  function automatic int exp_sel(int src, int mrd, int mw, int wrd, int ww);
    if (mw != 0 && mrd != 0 && mrd == src) return 1;
    if (ww != 0 && wrd != 0 && wrd == src) return 2;
    return 0;
  endfunction

  function automatic string fwd_tag(int src, int mrd, int mw, int wrd, int ww);
    bit mh = (mw != 0 && mrd == src);
    bit wh = (ww != 0 && wrd == src);
    if (src == 0) return "R4";
    if (mh && wh) return "R3";
    if (mh) return "R1";
    if (wh) return "R2";
    return "R11";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_inputs();
    @(negedge clk);
    #2;
    // R11: idle pipeline
    chk("R11", "pc_en", int'(pc_en), 1);
    chk("R11", "ifid_en", int'(ifid_en), 1);
    chk("R11", "fetch_en", int'(fetch_en), 1);
    chk("R11", "ifid_flush", int'(ifid_flush), 0);
    chk("R11", "idex_bubble", int'(idex_bub), 0);
    chk("R11", "redirect", int'(pc_redir), 0);
    chk("R11", "fwd_a", int'(fwd_a), 0);
    chk("R11", "fwd_b", int'(fwd_b), 0);

    // bypass sweep: every aliasing of execute sources against later stages
    for (int v = 0; v < 1024; v++) begin
      clear_inputs();
      ex_rs1 = v[1:0];
      ex_rs2 = v[3:2];
      mem_rd = v[5:4];
      mem_wr = v[6];
      wb_rd  = v[8:7];
      wb_wr  = v[9];
      @(negedge clk);
      #2;
      chk(fwd_tag(v[1:0], v[5:4], v[6], v[8:7], v[9]), "fwd_a", int'(fwd_a),
          exp_sel(v[1:0], v[5:4], v[6], v[8:7], v[9]));
      chk(fwd_tag(v[3:2], v[5:4], v[6], v[8:7], v[9]), "fwd_b", int'(fwd_b),
          exp_sel(v[3:2], v[5:4], v[6], v[8:7], v[9]));
      chk("R11", "idex_bubble", int'(idex_bub), 0);
    end

    // control sweep: interlock, port conflict, branch outcome
    for (int v = 0; v < 2048; v++) begin
      bit lu, ma, bt, raw_ld;
      string tag;
      clear_inputs();
      id_rs1  = v[1:0];
      id_rs2  = v[3:2];
      id_u1   = v[4];
      id_u2   = v[5];
      ex_rd   = v[7:6];
      ex_load = v[8];
      mem_acc = v[9];
      br      = v[10];
      raw_ld = v[8] && ((v[1:0] == v[7:6]) || (v[3:2] == v[7:6]));
      lu = v[8] && (v[7:6] != 0) &&
           ((v[4] && v[1:0] == v[7:6]) || (v[5] && v[3:2] == v[7:6]));
      ma = v[9];
      bt = v[10];
      if (lu && ma)            tag = "R8";
      else if (lu && bt)       tag = "R10";
      else if (lu)             tag = "R5";
      else if (bt)             tag = "R9";
      else if (ma)             tag = "R7";
      else if (raw_ld && v[7:6] == 0) tag = "R4";
      else if (raw_ld)         tag = "R6";
      else                     tag = "R10";
      @(negedge clk);
      #2;
      chk(tag, "idex_bubble", int'(idex_bub), int'(lu));
      chk(tag, "ifid_en", int'(ifid_en), int'(!lu));
      chk(tag, "ifid_flush", int'(ifid_flush), int'(!lu && (ma || bt)));
      chk(tag, "pc_en", int'(pc_en), int'(!lu && (!ma || bt)));
      chk(tag, "redirect", int'(pc_redir), int'(bt && !lu));
      chk(tag, "fetch_en", int'(fetch_en), int'(!ma));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule